// File: doc/BRIEF.md
# Packed 24-bit pixel unpacker

This block takes a stream of 16-bit data words from a pixel port and rebuilds 24-bit colour pixels from them. Each pixel has an 8-bit red, an 8-bit green and an 8-bit blue part. Three input words hold exactly two pixels. Pixel boundaries fall in the middle of the second word, so bytes from earlier words are kept in carry registers until the word that completes their pixel arrives. At one word per clock, the pixel rate is two thirds of the input clock rate.

A three-state phase machine follows the byte position inside the current group of three words. The states are `PH_FIRST`, `PH_SECOND` and `PH_THIRD`.
- An accepted word moves `PH_FIRST` to `PH_SECOND` (advance-1).
- An accepted word moves `PH_SECOND` to `PH_THIRD` (advance-2).
- An accepted word moves `PH_THIRD` back to `PH_FIRST` (wrap).
- A cycle with no accepted word keeps the state (hold).
- Reset, or the packed-mode enable going low, forces `PH_FIRST` (restart).

A word is accepted only in a cycle where both the enable and the input strobe are high. The output strobe rises in the cycle after the word that completes a pixel, and it stays high for one clock.

Top module: `pix24_unpack`

## Requirements
- R1: While reset is high, and in the first cycle after it, `pix_valid` is 0 and `pix_rgb` is 0. The next accepted word is taken as the first word of a group.
- R2: The first word of a group is stored: bits [7:0] are blue and bits [15:8] are green of pixel 0. The stored bytes do not change in a cycle with no accepted word.
- R3: The second word of a group completes pixel 0, with red taken from bits [7:0]. One clock later `pix_valid` is 1 and `pix_rgb` holds pixel 0.
- R4: The second word's bits [15:8] are stored as blue of pixel 1. The third word supplies green of pixel 1 in bits [7:0] and red of pixel 1 in bits [15:8]. One clock later `pix_valid` is 1 and `pix_rgb` holds pixel 1.
- R5: `pix_valid` is 0 in the cycle after a first-of-group word.
- R6: A cycle with `in_valid` low does not move the phase, drives `pix_valid` to 0 one clock later and leaves `pix_rgb` unchanged.
- R7: After the third word the phase returns to the first, so groups sent back to back decode correctly.
- R8: A cycle with `pack_en` low accepts no word, puts the phase back to the first, drives `pix_valid` to 0 and leaves `pix_rgb` unchanged.
- R9: `pix_valid` is high for exactly one clock per completed pixel: two pulses for every three accepted words.
- R10: `pix_rgb` is laid out as red in [23:16], green in [15:8] and blue in [7:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pack_en | input | 1 | Packed 24-bit mode enable |
| in_valid | input | 1 | Input word strobe |
| in_word | input | 16 | Packed input data word |
| pix_valid | output | 1 | One-clock strobe for a completed pixel |
| pix_rgb | output | 24 | Pixel as {red, green, blue} |

## Verification
The assertions assume two things about the inputs: reset is applied synchronously, and `pack_en` and `in_valid` are always known values, with `in_valid` counted only when `pack_en` is high. The stimulus changes every input only on the falling clock edge. Its gaps come from idle cycles with `in_valid` low and from single cycles with `pack_en` low. A new group is always started after an enable drop, so the expected pixel order stays defined.

// File: rtl/pix24_pkg.sv
`timescale 1ns/1ps
package pix24_pkg;
    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,
        PH_SECOND = 2'd1,
        PH_THIRD  = 2'd2
    } phase_e;
endpackage

// File: rtl/pix24_phase_fsm.sv
`timescale 1ns/1ps
module pix24_phase_fsm
    import pix24_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pack_en,
    input  logic   in_valid,
    output phase_e phase,
    output logic   adv
);
    phase_e phase_nxt;

    assign adv = pack_en && in_valid;

    always_comb begin
        phase_nxt = phase;
        if (!pack_en) begin
            phase_nxt = PH_FIRST;
        end else if (in_valid) begin
            unique case (phase)
                PH_FIRST:  phase_nxt = PH_SECOND;
                PH_SECOND: phase_nxt = PH_THIRD;
                PH_THIRD:  phase_nxt = PH_FIRST;
                default:   phase_nxt = PH_FIRST;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_FIRST;
        else     phase <= phase_nxt;
    end

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && phase == PH_THIRD) |=> (phase == PH_FIRST));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pack_en && !in_valid) |=> $stable(phase));

    // R8
    disable_chk: assert property (@(posedge clk) disable iff (rst)
        (!pack_en) |=> (phase == PH_FIRST));
endmodule

// File: rtl/pix24_carry_regs.sv
`timescale 1ns/1ps
module pix24_carry_regs
    import pix24_pkg::*;
#(
    parameter int CH_W = 8,
    localparam int WORD_W = 2 * CH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  phase_e            phase,
    input  logic [WORD_W-1:0] in_word,
    output logic [CH_W-1:0]   p0_blue,
    output logic [CH_W-1:0]   p0_green,
    output logic [CH_W-1:0]   p1_blue
);
    always_ff @(posedge clk) begin
        if (rst) begin
            p0_blue  <= '0;
            p0_green <= '0;
            p1_blue  <= '0;
        end else if (adv) begin
            unique case (phase)
                PH_FIRST: begin
                    p0_blue  <= in_word[CH_W-1:0];
                    p0_green <= in_word[WORD_W-1:CH_W];
                end
                PH_SECOND: p1_blue <= in_word[WORD_W-1:CH_W];
                PH_THIRD:  ;
                default:   ;
            endcase
        end
    end

    // R2
    carry_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv) |=> ($stable(p0_blue) && $stable(p0_green) && $stable(p1_blue)));
endmodule

// File: rtl/pix24_out_stage.sv
`timescale 1ns/1ps
module pix24_out_stage
    import pix24_pkg::*;
#(
    parameter int CH_W = 8,
    localparam int WORD_W = 2 * CH_W,
    localparam int PIX_W  = 3 * CH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  phase_e            phase,
    input  logic [WORD_W-1:0] in_word,
    input  logic [CH_W-1:0]   p0_blue,
    input  logic [CH_W-1:0]   p0_green,
    input  logic [CH_W-1:0]   p1_blue,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix_rgb
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_valid <= 1'b0;
            pix_rgb   <= '0;
        end else begin
            pix_valid <= 1'b0;
            if (adv) begin
                unique case (phase)
                    PH_FIRST: pix_valid <= 1'b0;
                    PH_SECOND: begin
                        pix_valid <= 1'b1;
                        pix_rgb   <= {in_word[CH_W-1:0], p0_green, p0_blue};
                    end
                    PH_THIRD: begin
                        pix_valid <= 1'b1;
                        pix_rgb   <= {in_word[WORD_W-1:CH_W], in_word[CH_W-1:0], p1_blue};
                    end
                    default: pix_valid <= 1'b0;
                endcase
            end
        end
    end

    // R5
    no_first_out_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && phase == PH_FIRST) |=> !pix_valid);

    // R9
    one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv) |=> (!pix_valid && $stable(pix_rgb)));

    // R3
    complete_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && phase != PH_FIRST) |=> pix_valid);
endmodule

// File: rtl/pix24_unpack.sv
`timescale 1ns/1ps
module pix24_unpack
    import pix24_pkg::*;
#(
    parameter int CH_W = 8,
    localparam int WORD_W = 2 * CH_W,
    localparam int PIX_W  = 3 * CH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pack_en,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix_rgb
);
    phase_e          phase;
    logic            adv;
    logic [CH_W-1:0] p0_blue;
    logic [CH_W-1:0] p0_green;
    logic [CH_W-1:0] p1_blue;

    pix24_phase_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pack_en  (pack_en),
        .in_valid (in_valid),
        .phase    (phase),
        .adv      (adv)
    );

    pix24_carry_regs #(.CH_W(CH_W)) u_carry (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .phase    (phase),
        .in_word  (in_word),
        .p0_blue  (p0_blue),
        .p0_green (p0_green),
        .p1_blue  (p1_blue)
    );

    pix24_out_stage #(.CH_W(CH_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .phase     (phase),
        .in_word   (in_word),
        .p0_blue   (p0_blue),
        .p0_green  (p0_green),
        .p1_blue   (p1_blue),
        .pix_valid (pix_valid),
        .pix_rgb   (pix_rgb)
    );

    // R8
    en_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!pack_en) |=> !pix_valid);
endmodule

// File: tb/sim_pix24_unpack.sv
`timescale 1ns/1ps
module sim_pix24_unpack;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pack_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        pix_valid;
    logic [23:0] pix_rgb;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [23:0] last_pix = '0;

    always #10 clk = ~clk;

    pix24_unpack u0 (
        .clk(clk), .rst(rst), .pack_en(pack_en), .in_valid(in_valid),
        .in_word(in_word), .pix_valid(pix_valid), .pix_rgb(pix_rgb)
    );

    // k=0: {G0,B0}; k=1: {B1,R0}; k=2: {R1,G1}; pixel = {R,G,B}
    function automatic logic [15:0] pack_word(input logic [23:0] p0, input logic [23:0] p1, input int k);
        case (k)
            0:       return {p0[15:8], p0[7:0]};
            1:       return {p1[7:0], p0[23:16]};
            default: return {p1[23:16], p1[15:8]};
        endcase
    endfunction

    task automatic check(input string tag, input logic exp_v, input logic [23:0] exp_p);
        n_cmp++;
        if (pix_valid !== exp_v) begin
            n_bad++;
            $display("FAIL %s pix_valid actual=%0b expected=%0b", tag, pix_valid, exp_v);
        end
        n_cmp++;
        if (pix_rgb !== exp_p) begin
            n_bad++;
            $display("FAIL %s pix_rgb actual=%06h expected=%06h", tag, pix_rgb, exp_p);
        end
    endtask

    task automatic step(input logic en, input logic v, input logic [15:0] w,
                        input logic exp_v, input logic [23:0] exp_p, input string tag);
        pack_en = en; in_valid = v; in_word = w;
        @(negedge clk);
        if (exp_v) last_pix = exp_p;
        check(tag, exp_v, exp_v ? exp_p : last_pix);
    endtask

    task automatic send_group(input logic [23:0] p0, input logic [23:0] p1, input int gap_max, input string tag);
        for (int k = 0; k < 3; k++) begin
            int gaps = (gap_max > 0) ? int'($urandom_range(gap_max)) : 0;
            for (int g = 0; g < gaps; g++)
                step(1'b1, 1'b0, 16'($urandom), 1'b0, 24'h0, "R6");
            case (k)
                0: step(1'b1, 1'b1, pack_word(p0, p1, 0), 1'b0, 24'h0, (tag == "") ? "R5" : tag);
                1: step(1'b1, 1'b1, pack_word(p0, p1, 1), 1'b1, p0, (tag == "") ? "R3" : tag);
                default: step(1'b1, 1'b1, pack_word(p0, p1, 2), 1'b1, p1, (tag == "") ? "R4" : tag);
            endcase
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        @(negedge clk);
        check("R1", 1'b0, 24'h0);
        rst = 1'b0;
        pack_en = 1'b1;
        @(negedge clk);
        check("R1", 1'b0, 24'h0);

        // R10: distinct bytes reveal field placement
        send_group(24'hA1B2C3, 24'hD4E5F6, 0, "R10");
        // R9: pulse ends after one clock
        step(1'b1, 1'b0, 16'hFFFF, 1'b0, 24'h0, "R9");
        // R7: back-to-back groups wrap
        send_group(24'h010203, 24'h040506, 0, "R7");
        send_group(24'h112233, 24'h445566, 0, "R7");
        // R2: gap after first word keeps carried bytes
        step(1'b1, 1'b1, pack_word(24'h778899, 24'hAABBCC, 0), 1'b0, 24'h0, "R5");
        for (int g = 0; g < 4; g++)
            step(1'b1, 1'b0, 16'h5A5A, 1'b0, 24'h0, "R2");
        step(1'b1, 1'b1, pack_word(24'h778899, 24'hAABBCC, 1), 1'b1, 24'h778899, "R2");
        step(1'b1, 1'b1, pack_word(24'h778899, 24'hAABBCC, 2), 1'b1, 24'hAABBCC, "R4");
        // R8: enable drop mid-group restarts phase; word seen while low is ignored
        step(1'b1, 1'b1, pack_word(24'hDEAD00, 24'hBEEF00, 0), 1'b0, 24'h0, "R5");
        step(1'b0, 1'b1, 16'h1234, 1'b0, 24'h0, "R8");
        send_group(24'h135790, 24'h246801, 0, "R8");
        // random stream with gaps
        for (int i = 0; i < 300; i++)
            send_group(24'($urandom), 24'($urandom), 2, "");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule